// File: doc/BRIEF.md
# Bidirectional I/O Port with Timer Override

This block is one parallel I/O port of a microcontroller-style peripheral. Software reaches it through a small register interface, with an address, a write strobe, a read strobe and a data bus. Two registers are mapped: a data register that drives per-pin output latches, and a direction register that sets which pins are driven. A read of the data register never returns the latches. It returns the live pad levels, after they pass through a synchronizer.

Every pin can also be claimed by a timer output-compare channel. While the channel holds a pin, that pin is driven with the timer's compare value and its output enable is on, whatever the direction bit says. Writes to the data register still land in the latch, so the software value takes over again as soon as the timer lets go. The top level sends the pad outputs and output enables to the I/O ring and takes the raw pad levels back in.

Top module: `ioport_ctl`

## Requirements
- R1: After reset, the direction register and the output latches are all zero, so with no timer override every `pad_oe` bit is 0 and `pad_out` is 0.
- R2: A read at address 0 (pin register) returns the synchronized pad level on every bit, whatever the direction bits and latch contents.
- R3: A write at address 0 stores `reg_wdata` in the output latches. For pins without a timer override, `pad_out` equals the latch from the cycle after the write edge.
- R4: With no override on a pin, its `pad_oe` equals its direction bit. A write at address 1 (direction register) takes effect on the write edge.
- R5: Latch bits written while a pin is an input are driven as soon as that pin's direction bit is set, with no further data write.
- R6: While `tmr_oc_en[i]` is 1, `pad_out[i]` equals `tmr_oc_val[i]` and `pad_oe[i]` is 1, regardless of direction bit i.
- R7: A data-register write to an overridden pin leaves that pin's output unchanged but updates its latch, which appears on the pin once the override is removed.
- R8: A read at address 1 returns the stored direction register.
- R9: `reg_rdata` is loaded on the clock edge at which `reg_rd` is sampled high, and it holds its value on every other cycle.
- R10: A pad change shows up in reads only after two clock edges of synchronization: a read sampled on the first or second edge after the change returns the old level, and a read on the third edge returns the new one.
- R11: Addresses 2 and 3 are unmapped. Writes to them change no state, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address: 0 pin/data, 1 direction |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data, valid one cycle after the strobe |
| pad_in | input | WIDTH | Raw pad input levels |
| tmr_oc_en | input | WIDTH | Per-pin timer output-compare ownership |
| tmr_oc_val | input | WIDTH | Per-pin timer compare output value |
| pad_out | output | WIDTH | Pad output value |
| pad_oe | output | WIDTH | Pad output enable |

## Verification
The embedded properties are checked on every cycle. They confirm that the latches and the direction register keep their value unless a write to their own address arrives, that unmapped writes leave both unchanged, that read data holds between read strobes, and that an overridden pin is always enabled and carries the timer value. Some behaviour needs a planned sequence of stimulus, and only the directed scenarios show it. That covers the exact synchronizer delay seen through reads, read-back of the live pad level rather than the latch, and latch contents written under override or as inputs reappearing on the pins later.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
    localparam int unsigned PORT_ADDR_W = 2;
    typedef logic [PORT_ADDR_W-1:0] port_addr_t;

    localparam port_addr_t ADDR_PIN = 2'd0;
    localparam port_addr_t ADDR_DIR = 2'd1;
endpackage

// File: rtl/ioport_sync.sv
module ioport_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.chain[LAST];

    initial begin
        if (STAGES < 2) $error("ioport_sync needs at least two stages");
    end
endmodule

// File: rtl/ioport_regs.sv
module ioport_regs
    import ioport_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  port_addr_t       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [WIDTH-1:0] reg_wdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] latch_out,
    output logic [WIDTH-1:0] dir_out,
    output logic [WIDTH-1:0] reg_rdata
);
    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic hit_pin, hit_dir;

    always_comb begin
        hit_pin = (reg_addr == ADDR_PIN);
        hit_dir = (reg_addr == ADDR_DIR);
        st_d = st_q;
        if (reg_wr && hit_pin) st_d.latch = reg_wdata;
        if (reg_wr && hit_dir) st_d.dir   = reg_wdata;
        if (reg_rd) begin
            if (hit_pin)      st_d.rdata = pin_sync;
            else if (hit_dir) st_d.rdata = st_q.dir;
            else              st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_out = st_q.latch;
    assign dir_out   = st_q.dir;
    assign reg_rdata = st_q.rdata;

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_PIN) |=> $stable(latch_out));

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_DIR) |=> $stable(dir_out));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R11
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != ADDR_PIN && reg_addr != ADDR_DIR)
        |=> ($stable(latch_out) && $stable(dir_out)));
endmodule

// File: rtl/ioport_pinmux.sv
module ioport_pinmux #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch_in,
    input  logic [WIDTH-1:0] dir_in,
    input  logic [WIDTH-1:0] oc_en,
    input  logic [WIDTH-1:0] oc_val,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            if (oc_en[i]) begin
                pin_out[i] = oc_val[i];
                pin_oe[i]  = 1'b1;
            end else begin
                pin_out[i] = latch_in[i];
                pin_oe[i]  = dir_in[i];
            end
        end
    end
endmodule

// File: rtl/ioport_ctl.sv
module ioport_ctl
    import ioport_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORT_ADDR_W-1:0] reg_addr,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [WIDTH-1:0]       reg_wdata,
    output logic [WIDTH-1:0]       reg_rdata,
    input  logic [WIDTH-1:0]       pad_in,
    input  logic [WIDTH-1:0]       tmr_oc_en,
    input  logic [WIDTH-1:0]       tmr_oc_val,
    output logic [WIDTH-1:0]       pad_out,
    output logic [WIDTH-1:0]       pad_oe
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;

    ioport_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    ioport_regs #(.WIDTH(WIDTH)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .pin_sync  (pin_sync),
        .latch_out (latch_q),
        .dir_out   (dir_q),
        .reg_rdata (reg_rdata)
    );

    ioport_pinmux #(.WIDTH(WIDTH)) mux_i (
        .latch_in (latch_q),
        .dir_in   (dir_q),
        .oc_en    (tmr_oc_en),
        .oc_val   (tmr_oc_val),
        .pin_out  (pad_out),
        .pin_oe   (pad_oe)
    );

    // R6
    oc_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & tmr_oc_en) == tmr_oc_en)
        && ((pad_out & tmr_oc_en) == (tmr_oc_val & tmr_oc_en)));

    // R4
    oe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~tmr_oc_en) == (dir_q & ~tmr_oc_en)));
endmodule

// File: tb/ioport_ctl_tb.sv
module ioport_ctl_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] tmr_oc_en = '0;
    logic [W-1:0] tmr_oc_val = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] rd_val;

    always #10 clk = ~clk;

    ioport_ctl #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .tmr_oc_en(tmr_oc_en), .tmr_oc_val(tmr_oc_val),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);
        rd(2'd1, rd_val);
        check("R1 dir", rd_val, 8'h00);
    endtask

    task automatic t_latch_as_input();
        pad_in = 8'h3C;
        wr(2'd0, 8'hA5);
        check("R3 out", pad_out, 8'hA5);
        check("R4 oe input", pad_oe, 8'h00);
        idle(2);
        rd(2'd0, rd_val);
        check("R2 pin not latch", rd_val, 8'h3C);
    endtask

    task automatic t_direction();
        wr(2'd1, 8'h0F);
        check("R4 oe", pad_oe, 8'h0F);
        check("R5 out", pad_out, 8'hA5);
        rd(2'd1, rd_val);
        check("R8 dir", rd_val, 8'h0F);
        pad_in = 8'h5A;
        idle(3);
        rd(2'd0, rd_val);
        check("R2 live with outputs", rd_val, 8'h5A);
    endtask

    task automatic t_read_hold();
        rd(2'd1, rd_val);
        pad_in = 8'hFF;
        idle(4);
        check("R9 hold", reg_rdata, 8'h0F);
    endtask

    task automatic t_sync_delay();
        pad_in = 8'h3C;
        idle(4);
        @(negedge clk);
        pad_in = 8'hC3; reg_addr = 2'd0; reg_rd = 1'b1;
        @(negedge clk);
        check("R10 first edge", reg_rdata, 8'h3C);
        @(negedge clk);
        check("R10 second edge", reg_rdata, 8'h3C);
        @(negedge clk);
        reg_rd = 1'b0;
        check("R10 third edge", reg_rdata, 8'hC3);
    endtask

    task automatic t_override();
        @(negedge clk);
        tmr_oc_en = 8'h81; tmr_oc_val = 8'h80;
        @(negedge clk);
        check("R6 out", pad_out, 8'hA4);
        check("R6 oe", pad_oe, 8'h8F);
        wr(2'd0, 8'hFF);
        check("R7 out under override", pad_out, 8'hFE);
        @(negedge clk);
        tmr_oc_en = 8'h00;
        @(negedge clk);
        check("R7 latch after release", pad_out, 8'hFF);
        check("R7 oe after release", pad_oe, 8'h0F);
    endtask

    task automatic t_unmapped();
        wr(2'd2, 8'h00);
        wr(2'd3, 8'hF0);
        check("R11 out", pad_out, 8'hFF);
        check("R11 oe", pad_oe, 8'h0F);
        rd(2'd2, rd_val);
        check("R11 read zero", rd_val, 8'h00);
        rd(2'd3, rd_val);
        check("R11 read zero hi", rd_val, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_latch_as_input();
        t_direction();
        t_read_hold();
        t_sync_delay();
        t_override();
        t_unmapped();
        idle(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule